// File: doc/BRIEF.md
# VPW Invalid Symbol Detector

This block watches the receive line of a variable-pulse-width serial bus. The line reaches it only after an upstream glitch filter has removed very short spikes. The block times every stable level in microseconds, using a tick that it derives from the system clock with its own divider. A level that ends before the minimum valid symbol time counts as noise. Such a level raises a sticky invalid-bit flag, drops the receive-enable output and fires a one-cycle pulse that cancels the transmits queued for the current frame.

After an error the block stays locked out until the line has rested at its passive level for a full end-of-frame gap, timed from the last edge. This means a bad pulse seen on an idle bus also needs a fresh gap after it. The error can be raised only once per frame. It is suppressed while the node is in sleep or filter mode and is not transmitting. Software clears the flag by reading the error register. The flag also stays cleared while the block is disabled.

Top module: `vpw_noise_guard`

## Requirements
- R1: Level durations are measured in microseconds: an internal divider produces one tick every CLK_PER_US clock cycles, and the duration count restarts at 0 on every edge of `rx_i`.
- R2: A level that lasts at least MIN_SYM_US microseconds before the next edge raises no error: `inv_bit_o` stays 0 and `tx_cancel_o` stays low.
- R3: A level shorter than MIN_SYM_US that ends with an edge sets `inv_bit_o` to 1 one clock after that edge. In the same cycle it pulses `tx_cancel_o` high for exactly one cycle and drops `rx_en_o` to 0.
- R4: During the lockout that follows an error, further short levels raise no second `tx_cancel_o` pulse. The error occurs at most once per frame.
- R5: The lockout ends, and `rx_en_o` returns to 1, once `rx_i` has stayed at the passive level 0 for EOF_US microseconds with no edge.
- R6: The end-of-frame gap is timed from the last edge after the bad pulse, including a bad pulse that arrived on an idle bus. While that low gap is shorter than EOF_US, `rx_en_o` stays 0.
- R7: While (`sleep_i` or `filt_i`) is 1 and `tx_active_i` is 0, short levels are ignored: no flag, no cancel, no lockout. When `tx_active_i` is 1 in those modes, short levels are flagged as in R3.
- R8: A one-cycle pulse on `err_rd_i` clears `inv_bit_o`. If a new error is detected in the same cycle, the set wins.
- R9: Reset clears `inv_bit_o`. While `en_i` is 0 or `dis_i` is 1, `inv_bit_o` is held at 0, `rx_en_o` is 0, and any lockout is abandoned, so `rx_en_o` returns to 1 as soon as the block is active again.
- R10: The duration count saturates and does not wrap. A level of any length beyond EOF_US counts as a valid symbol when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Filtered bus receive level (0 = passive) |
| en_i | input | 1 | Block enable |
| dis_i | input | 1 | Block disable override |
| sleep_i | input | 1 | Sleep mode |
| filt_i | input | 1 | Filter mode |
| tx_active_i | input | 1 | Node is currently transmitting |
| err_rd_i | input | 1 | Error register read strobe |
| inv_bit_o | output | 1 | Sticky invalid-bit flag |
| rx_en_o | output | 1 | Reception allowed |
| tx_cancel_o | output | 1 | One-cycle pulse cancelling queued transmits |

## Verification
The bench uses CLK_PER_US=2, MIN_SYM_US=35 and EOF_US=60, so a full end-of-frame gap takes only 120 cycles. This makes lockout entry, partial gaps and lockout exit cheap to exercise many times. With EOF_US=60 the duration counter is six bits wide. A 90 µs idle level would therefore wrap to a value below the symbol minimum if the count did not saturate, and the saturation check depends on that. Pulses of 30 µs and 40 µs sit 5 µs on either side of the symbol limit. This is far outside the one-tick phase uncertainty, so they test the microsecond scaling and not just the comparison.

// File: rtl/vpw_guard_pkg.sv
package vpw_guard_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_LOCK = 1'b1
  } guard_st_e;
endpackage

// File: rtl/vpw_us_tick.sv
module vpw_us_tick #(
  parameter int unsigned CLK_PER_US = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_PER_US <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CLK_PER_US);
      localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/vpw_level_timer.sv
module vpw_level_timer #(
  parameter int unsigned SAT = 280,
  localparam int unsigned CW = $clog2(SAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          edge_o,
  output logic          lvl_o,
  output logic [CW-1:0] dur_o
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic          lvl_q;
  logic [CW-1:0] dur_q;

  assign edge_o = (rx_i != lvl_q);
  assign lvl_o  = lvl_q;
  assign dur_o  = dur_q;

  // reset value is saturated so the first level after reset is not short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      dur_q <= SAT_V;
    end else begin
      lvl_q <= rx_i;
      if (edge_o)                         dur_q <= '0;
      else if (tick_i && dur_q != SAT_V)  dur_q <= dur_q + 1'b1;
    end
  end

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_q == SAT_V && !edge_o) |=> dur_q == SAT_V);
  p_edge_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> dur_q == '0);
endmodule

// File: rtl/vpw_noise_guard.sv
module vpw_noise_guard
  import vpw_guard_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned MIN_SYM_US = 35,
  parameter int unsigned EOF_US     = 280
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic en_i,
  input  logic dis_i,
  input  logic sleep_i,
  input  logic filt_i,
  input  logic tx_active_i,
  input  logic err_rd_i,
  output logic inv_bit_o,
  output logic rx_en_o,
  output logic tx_cancel_o
);
  localparam int unsigned CW = $clog2(EOF_US + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_SYM_US);
  localparam logic [CW-1:0] EOF_V = CW'(EOF_US);

  logic          tick;
  logic          edge_det;
  logic          lvl;
  logic [CW-1:0] dur;

  vpw_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  vpw_level_timer #(.SAT(EOF_US)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_i   (rx_i),
    .edge_o (edge_det),
    .lvl_o  (lvl),
    .dur_o  (dur)
  );

  guard_st_e st_q;
  logic      flag_q, cancel_q;
  logic      active, inhibit, short_ev, gap_done;

  assign active   = en_i && !dis_i;
  assign inhibit  = (sleep_i || filt_i) && !tx_active_i;
  assign short_ev = active && !inhibit && (st_q == ST_RUN) && edge_det && (dur < MIN_V);
  assign gap_done = !edge_det && !lvl && (dur >= EOF_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      flag_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else if (!active) begin
      st_q     <= ST_RUN;
      flag_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cancel_q <= short_ev;
      if (short_ev)       flag_q <= 1'b1;
      else if (err_rd_i)  flag_q <= 1'b0;
      if (short_ev)                          st_q <= ST_LOCK;
      else if (st_q == ST_LOCK && gap_done)  st_q <= ST_RUN;
    end
  end

  assign inv_bit_o   = flag_q;
  assign tx_cancel_o = cancel_q;
  assign rx_en_o     = active && (st_q == ST_RUN);

  p_cancel_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cancel_o |-> (inv_bit_o && !rx_en_o));
  p_cancel_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cancel_o |=> !tx_cancel_o);
  p_inactive_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || dis_i) |=> (!inv_bit_o && !tx_cancel_o));
  p_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_cancel_o) |-> $past(!(sleep_i || filt_i) || tx_active_i));
  p_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_rd_i && !short_ev) |=> !inv_bit_o);
endmodule

// File: tb/sim_vpw_noise_guard.sv
module sim_vpw_noise_guard;
  localparam int DIV = 2;
  localparam int MIN = 35;
  localparam int EOF = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 0, en = 0, dis = 0, slp = 0, flt = 0, txa = 0, rd = 0;
  logic inv, rxen, cancel;
  int   total = 0, bad = 0;
  bit   done = 0;
  int   exp_q[$];

  always #2 clk = ~clk;

  vpw_noise_guard #(.CLK_PER_US(DIV), .MIN_SYM_US(MIN), .EOF_US(EOF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .en_i(en), .dis_i(dis),
    .sleep_i(slp), .filt_i(flt), .tx_active_i(txa), .err_rd_i(rd),
    .inv_bit_o(inv), .rx_en_o(rxen), .tx_cancel_o(cancel));

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic hold(logic lv, int us);
    rx = lv;
    repeat (us * DIV) @(negedge clk);
  endtask

  task automatic expect_err(string req);
    exp_q.push_back(1);
    $display("expect error (%s)", req);
  endtask

  task automatic drained(string req);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s pending=%0d exp=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor: every cancel pulse must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && cancel) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected cancel act=1 exp=0");
      end else begin
        void'(exp_q.pop_front());
        chk("R3 flag at cancel", inv, 1'b1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset flag", inv, 1'b0);
    chk("R9 reset rx_en", rxen, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1;
    repeat (2) @(negedge clk);
    chk("R9 enabled rx_en", rxen, 1'b1);

    // R2 valid symbols
    hold(1, 50); hold(0, 40); hold(1, 45); hold(0, 70);
    chk("R2 no flag", inv, 1'b0);
    chk("R2 rx_en", rxen, 1'b1);
    drained("R2");

    // R1/R3 30us high is short
    hold(1, 30);
    expect_err("R3");
    hold(0, 2);
    chk("R3 flag set", inv, 1'b1);
    chk("R3 rx locked", rxen, 1'b0);
    drained("R3");

    // R4 short pulse in lockout, R6 partial gap
    hold(0, 18); hold(1, 10); hold(0, 30);
    chk("R6 gap short still locked", rxen, 1'b0);
    drained("R4 single cancel");
    hold(0, 35);
    chk("R5 lockout ends", rxen, 1'b1);
    chk("R8 flag sticky before read", inv, 1'b1);

    // R8 read clears
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
    chk("R8 read cleared", inv, 1'b0);

    // R1 40us is valid
    hold(1, 40); hold(0, 70);
    chk("R1 40us valid", inv, 1'b0);
    drained("R1");

    // R7 sleep without tx ignored
    slp = 1;
    hold(1, 20); hold(0, 70);
    chk("R7 sleep ignored", inv, 1'b0);
    chk("R7 sleep rx_en", rxen, 1'b1);
    drained("R7 sleep");
    txa = 1;
    hold(1, 20);
    expect_err("R7");
    hold(0, 2);
    chk("R7 sleep+tx flagged", inv, 1'b1);
    drained("R7 tx");
    slp = 0; txa = 0;
    hold(0, 70);
    rd = 1; @(negedge clk); rd = 0;
    flt = 1;
    hold(1, 15); hold(0, 70);
    chk("R7 filter ignored", inv, 1'b0);
    drained("R7 filter");
    flt = 0;

    // R9 disable clears and abandons lockout
    hold(1, 20);
    expect_err("R9");
    hold(0, 2);
    chk("R9 flag before dis", inv, 1'b1);
    dis = 1; repeat (2) @(negedge clk);
    chk("R9 dis clears flag", inv, 1'b0);
    chk("R9 dis rx_en", rxen, 1'b0);
    dis = 0; @(negedge clk);
    chk("R9 lockout abandoned", rxen, 1'b1);
    drained("R9");

    // R6 bad pulse on idle bus
    hold(0, 90);
    hold(1, 12);
    expect_err("R6");
    hold(0, 50);
    chk("R6 idle pulse locked", rxen, 1'b0);
    hold(0, 15);
    chk("R6 idle gap done", rxen, 1'b1);
    rd = 1; @(negedge clk); rd = 0;

    // R10 long idle must not wrap
    hold(0, 90); hold(1, 50); hold(0, 10);
    chk("R10 no wrap flag", inv, 1'b0);
    chk("R10 rx_en", rxen, 1'b1);
    drained("R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule